// File: doc/BRIEF.md
# Three-Level Single-Phase Space-Vector State Sequencer

This block drives the eight gates of a single-phase full bridge made of two three-level neutral-clamped legs. The bridge is fed from an impedance-source network. An outside controller works out the sector and the dwell times and hands over one parameter set per update: a sector code, two active-vector dwell counts, a shoot-through count and a mode bit. The block holds that set in a shadow register. It copies the set into its working register only when the free-running carrier wraps, so one switching period never mixes two sets.

In each carrier period the block plays five slots in a fixed order: a head shoot-through slot, the first active vector, the middle vector, the second active vector and a tail shoot-through slot. The shoot-through time is split across the head and tail slots. Which vectors are used, and in which order, depends on the sector. The order is chosen so that the two redundant half-voltage states both appear in every period.

In the modified mode, the head and tail slots use incomplete shoot-through states instead of full ones. In these states three switches of one leg conduct. They always come as a matched pair within the period.

Top module: `npc3_svm_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `gate_o` is 8'h00 after that edge.
- R2: Each leg nibble uses bit0..bit3 for its outer-upper, inner-upper, inner-lower and outer-lower switch. Leg A is `gate_o[3:0]` and leg B is `gate_o[7:4]`. The encodings are: level +1 = 4'b0011, level 0 = 4'b0110, level -1 = 4'b1100, full short = 4'b1111, upper-three short = 4'b0111, lower-three short = 4'b1110. No other nibble appears after reset.
- R3: The carrier counts 0..PERIOD-1 and then wraps. `gate_o` is registered and reflects the count of the previous cycle, so the pattern repeats every PERIOD cycles.
- R4: Sector codes 0..7 play these (A,B) vector triples. 0: (0,-1),(0,0),(1,0). 1: (0,-1),(1,-1),(1,0). 2: (1,0),(1,-1),(0,-1). 3: (1,0),(0,0),(0,-1). 4: (0,1),(0,0),(-1,0). 5: (0,1),(-1,1),(-1,0). 6: (-1,0),(-1,1),(0,1). 7: (-1,0),(0,0),(0,1).
- R5: Let S be the shoot-through count. The head slot lasts floor(S/2) counts and the tail slot lasts S-floor(S/2). The first vector lasts dwell A, the last vector lasts dwell B, and the middle vector fills the rest of the period.
- R6: With the mode bit low, both shoot-through slots drive all eight gates high (8'hFF).
- R7: With the mode bit high, the head and tail slots use incomplete states, in (A,B) order. Sectors 0,1: head (upper-three,-1), tail (+1,lower-three). Sectors 2,3: the same two states swapped. Sectors 4,5: head (lower-three,+1), tail (-1,upper-three). Sectors 6,7: the same two states swapped.
- R8: At capture, the shoot-through count is clamped to PERIOD. Dwell A is then clamped to what remains, and dwell B to what remains after that.
- R9: An update strobe only loads the shadow set. The working set changes only at the carrier wrap. A strobe in the wrap cycle itself takes effect one period later.
- R10: A slot of zero length is skipped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_valid_i | input | 1 | Load strobe for the shadow parameter set |
| upd_sector_i | input | 3 | Sector code 0..7 |
| upd_modified_i | input | 1 | 1 selects incomplete shoot-through slots |
| upd_dwell_a_i | input | CNT_W | First active vector dwell, in counts |
| upd_dwell_b_i | input | CNT_W | Last active vector dwell, in counts |
| upd_st_i | input | CNT_W | Total shoot-through time, in counts |
| gate_o | output | 8 | Gate drives, leg A in [3:0], leg B in [7:4] |

## Verification
Parameter capture and the period hand-over can fall on the same clock edge. This happens when the strobe arrives in the cycle where the carrier wraps. The bench provokes it by waiting for the model's count to reach PERIOD-1 before raising the strobe. It then judges, on every clock, that the period which starts at that edge still plays the earlier set and that the new set appears one period later. Saturation and odd shoot-through splits are provoked in the same run, so that clamped boundaries meet that hand-over as well.

// File: rtl/npc3_svm_pkg.sv
// Shared types for the three-level space-vector sequencer.
// Assumes: leg nibble bit0 = outer-upper switch ... bit3 = outer-lower switch.
package npc3_svm_pkg;

    typedef enum logic [2:0] {
        SLOT_HEAD = 3'd0,
        SLOT_VA   = 3'd1,
        SLOT_MID  = 3'd2,
        SLOT_VB   = 3'd3,
        SLOT_TAIL = 3'd4
    } slot_e;

    typedef enum logic [2:0] {
        LC_NEG  = 3'd0,
        LC_ZERO = 3'd1,
        LC_POS  = 3'd2,
        LC_FULL = 3'd3,
        LC_TOP3 = 3'd4,
        LC_BOT3 = 3'd5
    } leg_e;

    // Switch pattern for one leg state
    function automatic logic [3:0] leg_nibble(input leg_e c);
        case (c)
            LC_POS:  leg_nibble = 4'b0011;
            LC_ZERO: leg_nibble = 4'b0110;
            LC_NEG:  leg_nibble = 4'b1100;
            LC_FULL: leg_nibble = 4'b1111;
            LC_TOP3: leg_nibble = 4'b0111;
            LC_BOT3: leg_nibble = 4'b1110;
            default: leg_nibble = 4'b0110;
        endcase
    endfunction

endpackage

// File: rtl/npc3_svm_carrier.sv
// Free-running period counter. Counts 0..PERIOD-1, flags the last count.
// Assumes PERIOD >= 2.
module npc3_svm_carrier #(
    parameter int PERIOD = 400,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Advance the carrier, wrap after the last count
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == LAST);

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(PERIOD));
    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> cnt_q == '0);

endmodule

// File: rtl/npc3_svm_param_bank.sv
// Shadow and working parameter registers. Clamps counts on capture and
// hands the shadow set to the working set only at carrier wrap.
module npc3_svm_param_bank #(
    parameter int PERIOD = 400,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap_i,
    input  logic          upd_valid_i,
    input  logic [2:0]    upd_sector_i,
    input  logic          upd_modified_i,
    input  logic [CW-1:0] upd_dwell_a_i,
    input  logic [CW-1:0] upd_dwell_b_i,
    input  logic [CW-1:0] upd_st_i,
    output logic [2:0]    act_sector_o,
    output logic          act_modified_o,
    output logic [CW-1:0] act_dwell_a_o,
    output logic [CW-1:0] act_dwell_b_o,
    output logic [CW-1:0] act_st_o
);

    localparam logic [CW-1:0] FULL = CW'(PERIOD);

    logic [CW-1:0] st_sat, a_sat, b_sat, room_a, room_b;
    logic [2:0]    sh_sector;
    logic          sh_mod;
    logic [CW-1:0] sh_a, sh_b, sh_st;

    // Clamp the incoming counts so they never exceed one period
    always_comb begin
        st_sat = (upd_st_i > FULL) ? FULL : upd_st_i;
        room_a = FULL - st_sat;
        a_sat  = (upd_dwell_a_i > room_a) ? room_a : upd_dwell_a_i;
        room_b = room_a - a_sat;
        b_sat  = (upd_dwell_b_i > room_b) ? room_b : upd_dwell_b_i;
    end

    // Shadow set: written on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_sector <= '0; sh_mod <= 1'b0;
            sh_a <= '0; sh_b <= '0; sh_st <= '0;
        end else if (upd_valid_i) begin
            sh_sector <= upd_sector_i; sh_mod <= upd_modified_i;
            sh_a <= a_sat; sh_b <= b_sat; sh_st <= st_sat;
        end
    end

    // Working set: taken from the shadow only at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sector_o <= '0; act_modified_o <= 1'b0;
            act_dwell_a_o <= '0; act_dwell_b_o <= '0; act_st_o <= '0;
        end else if (wrap_i) begin
            act_sector_o <= sh_sector; act_modified_o <= sh_mod;
            act_dwell_a_o <= sh_a; act_dwell_b_o <= sh_b; act_st_o <= sh_st;
        end
    end

    assert_hold_mid_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable({act_sector_o, act_modified_o, act_dwell_a_o,
                             act_dwell_b_o, act_st_o}));
    assert_sum_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({2'b00, act_st_o} + {2'b00, act_dwell_a_o} + {2'b00, act_dwell_b_o})
            <= (CW + 2)'(PERIOD));

endmodule

// File: rtl/npc3_svm_slot_decode.sv
// Maps the carrier count to one of five slots from the working counts.
// Assumes st + dwell_a + dwell_b <= PERIOD (guaranteed by the bank).
module npc3_svm_slot_decode
    import npc3_svm_pkg::*;
#(
    parameter int PERIOD = 400,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] dwell_a_i,
    input  logic [CW-1:0] dwell_b_i,
    input  logic [CW-1:0] st_i,
    output slot_e         slot_o
);

    logic [CW-1:0] head_len, tail_len, end_head, end_va, end_mid, end_vb;

    // Slot boundaries; an empty slot has equal start and end
    always_comb begin
        head_len = st_i >> 1;
        tail_len = st_i - head_len;
        end_head = head_len;
        end_va   = head_len + dwell_a_i;
        end_vb   = CW'(PERIOD) - tail_len;
        end_mid  = end_vb - dwell_b_i;
        if (cnt_i < end_head)     slot_o = SLOT_HEAD;
        else if (cnt_i < end_va)  slot_o = SLOT_VA;
        else if (cnt_i < end_mid) slot_o = SLOT_MID;
        else if (cnt_i < end_vb)  slot_o = SLOT_VB;
        else                      slot_o = SLOT_TAIL;
    end

    assert_slot_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |-> (slot_o >= $past(slot_o)));

endmodule

// File: rtl/npc3_svm_state_map.sv
// Turns sector, mode and slot into the registered gate pattern of both legs.
// Assumes sector codes 0..3 are the positive half, 4..7 the negative half.
module npc3_svm_state_map
    import npc3_svm_pkg::*;
#(
    parameter int LEGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sector_i,
    input  logic          modified_i,
    input  slot_e         slot_i,
    output logic [4*LEGS-1:0] gate_o
);

    leg_e lv [LEGS];
    leg_e vx_a, vx_b, vy_a, vy_b, ix_a, ix_b, iy_a, iy_b, md_a, md_b;
    logic pos_half, outer, mid_active;
    logic [3:0] nib [LEGS];
    logic [4*LEGS-1:0] gate_d;

    // Pick the leg states for the current slot
    always_comb begin
        pos_half   = ~sector_i[2];
        outer      = sector_i[1];
        mid_active = sector_i[1] ^ sector_i[0];
        vx_a = LC_ZERO;                          vx_b = pos_half ? LC_NEG : LC_POS;
        vy_a = pos_half ? LC_POS : LC_NEG;       vy_b = LC_ZERO;
        ix_a = pos_half ? LC_TOP3 : LC_BOT3;     ix_b = pos_half ? LC_NEG : LC_POS;
        iy_a = pos_half ? LC_POS : LC_NEG;       iy_b = pos_half ? LC_BOT3 : LC_TOP3;
        md_a = mid_active ? (pos_half ? LC_POS : LC_NEG) : LC_ZERO;
        md_b = mid_active ? (pos_half ? LC_NEG : LC_POS) : LC_ZERO;
        lv[0] = LC_ZERO; lv[1] = LC_ZERO;
        case (slot_i)
            SLOT_HEAD: begin
                lv[0] = !modified_i ? LC_FULL : (outer ? iy_a : ix_a);
                lv[1] = !modified_i ? LC_FULL : (outer ? iy_b : ix_b);
            end
            SLOT_VA:   begin lv[0] = outer ? vy_a : vx_a; lv[1] = outer ? vy_b : vx_b; end
            SLOT_MID:  begin lv[0] = md_a; lv[1] = md_b; end
            SLOT_VB:   begin lv[0] = outer ? vx_a : vy_a; lv[1] = outer ? vx_b : vy_b; end
            SLOT_TAIL: begin
                lv[0] = !modified_i ? LC_FULL : (outer ? ix_a : iy_a);
                lv[1] = !modified_i ? LC_FULL : (outer ? ix_b : iy_b);
            end
            default:   begin lv[0] = LC_ZERO; lv[1] = LC_ZERO; end
        endcase
    end

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        assign nib[g] = leg_nibble(lv[g]);
        assign gate_d[4*g +: 4] = nib[g];
    end

    // Register the gate drives; all off in reset
    always_ff @(posedge clk) begin
        if (!rst_n) gate_o <= '0;
        else        gate_o <= gate_d;
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> gate_o == '0);
    assert_legal_leg_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (gate_o[3:0] inside {4'b0011, 4'b0110, 4'b1100,
                                              4'b1111, 4'b0111, 4'b1110}));
    assert_legal_leg_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (gate_o[7:4] inside {4'b0011, 4'b0110, 4'b1100,
                                              4'b1111, 4'b0111, 4'b1110}));
    assert_no_partial_basic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !modified_i |=> !(gate_o[3:0] inside {4'b0111, 4'b1110}) &&
                        !(gate_o[7:4] inside {4'b0111, 4'b1110}));
    assert_one_partial_leg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((gate_o[3:0] inside {4'b0111, 4'b1110}) &&
          (gate_o[7:4] inside {4'b0111, 4'b1110})));

endmodule

// File: rtl/npc3_svm_sequencer.sv
// Top: three-level single-phase space-vector state sequencer.
// Plays head shoot-through, two active vectors around a middle vector and a
// tail shoot-through every PERIOD clocks. Parameters are double-buffered.
module npc3_svm_sequencer
    import npc3_svm_pkg::*;
#(
    parameter int PERIOD = 400,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid_i,
    input  logic [2:0]       upd_sector_i,
    input  logic             upd_modified_i,
    input  logic [CNT_W-1:0] upd_dwell_a_i,
    input  logic [CNT_W-1:0] upd_dwell_b_i,
    input  logic [CNT_W-1:0] upd_st_i,
    output logic [7:0]       gate_o
);

    logic [CNT_W-1:0] cnt, act_a, act_b, act_st;
    logic             wrap, act_mod;
    logic [2:0]       act_sector;
    slot_e            slot;

    npc3_svm_carrier #(.PERIOD(PERIOD), .CW(CNT_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .wrap_o(wrap)
    );

    npc3_svm_param_bank #(.PERIOD(PERIOD), .CW(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap),
        .upd_valid_i(upd_valid_i), .upd_sector_i(upd_sector_i),
        .upd_modified_i(upd_modified_i), .upd_dwell_a_i(upd_dwell_a_i),
        .upd_dwell_b_i(upd_dwell_b_i), .upd_st_i(upd_st_i),
        .act_sector_o(act_sector), .act_modified_o(act_mod),
        .act_dwell_a_o(act_a), .act_dwell_b_o(act_b), .act_st_o(act_st)
    );

    npc3_svm_slot_decode #(.PERIOD(PERIOD), .CW(CNT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
        .dwell_a_i(act_a), .dwell_b_i(act_b), .st_i(act_st), .slot_o(slot)
    );

    npc3_svm_state_map #(.LEGS(2)) u_map (
        .clk(clk), .rst_n(rst_n), .sector_i(act_sector),
        .modified_i(act_mod), .slot_i(slot), .gate_o(gate_o)
    );

endmodule

// File: tb/npc3_svm_sequencer_tb.sv
// Bench: behavioural per-cycle model, compared with gate_o on every clock.
module npc3_svm_sequencer_tb;

    localparam int P  = 24;
    localparam int CW = $clog2(P + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_valid = 1'b0;
    logic [2:0]    sec = '0;
    logic          mode = 1'b0;
    logic [CW-1:0] da = '0, db = '0, st = '0;
    logic [7:0]    gate;

    int n_tests = 0, n_fail = 0;
    bit armed = 0, done = 0;
    string cur_req = "R1";

    // model state
    int m_cnt = 0;
    int sh_sec = 0, sh_mod = 0, sh_a = 0, sh_b = 0, sh_st = 0;
    int ac_sec = 0, ac_mod = 0, ac_a = 0, ac_b = 0, ac_st = 0;
    logic [7:0] exp_g = 8'h00;

    // leg codes: 1,0,-1 levels; 2 full short; 3 upper three; 4 lower three
    int la [8][5] = '{'{3,0,0,1,1}, '{3,0,1,1,1}, '{1,1,1,0,3}, '{1,1,0,0,3},
                      '{4,0,0,-1,-1}, '{4,0,-1,-1,-1}, '{-1,-1,-1,0,4}, '{-1,-1,0,0,4}};
    int lb [8][5] = '{'{-1,-1,0,0,4}, '{-1,-1,-1,0,4}, '{4,0,-1,-1,-1}, '{4,0,0,-1,-1},
                      '{1,1,0,0,3}, '{1,1,1,0,3}, '{3,0,1,1,1}, '{3,0,0,1,1}};

    always #5 clk = ~clk;

    npc3_svm_sequencer #(.PERIOD(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_valid_i(upd_valid),
        .upd_sector_i(sec), .upd_modified_i(mode),
        .upd_dwell_a_i(da), .upd_dwell_b_i(db), .upd_st_i(st), .gate_o(gate)
    );

    function automatic logic [3:0] nib(input int c);
        case (c)
            1: return 4'b0011;
            0: return 4'b0110;
            -1: return 4'b1100;
            2: return 4'b1111;
            3: return 4'b0111;
            default: return 4'b1110;
        endcase
    endfunction

    function automatic logic [7:0] model_gates(input int c);
        int h, tl, s, ca, cb;
        h = ac_st / 2;
        tl = ac_st - h;
        if (c < h) s = 0;
        else if (c < h + ac_a) s = 1;
        else if (c < P - tl - ac_b) s = 2;
        else if (c < P - tl) s = 3;
        else s = 4;
        ca = la[ac_sec][s];
        cb = lb[ac_sec][s];
        if ((s == 0 || s == 4) && ac_mod == 0) begin ca = 2; cb = 2; end
        return {nib(cb), nib(ca)};
    endfunction

    // reference model, advanced on every clock edge
    always @(posedge clk) begin
        armed = 1;
        if (!rst_n) begin
            m_cnt = 0; exp_g = 8'h00;
            sh_sec = 0; sh_mod = 0; sh_a = 0; sh_b = 0; sh_st = 0;
            ac_sec = 0; ac_mod = 0; ac_a = 0; ac_b = 0; ac_st = 0;
        end else begin
            exp_g = model_gates(m_cnt);
            if (m_cnt == P - 1) begin
                ac_sec = sh_sec; ac_mod = sh_mod; ac_a = sh_a; ac_b = sh_b; ac_st = sh_st;
                m_cnt = 0;
            end else m_cnt++;
            if (upd_valid) begin
                int r;
                sh_sec = int'(sec); sh_mod = int'(mode);
                sh_st = (int'(st) > P) ? P : int'(st);
                r = P - sh_st;
                sh_a = (int'(da) > r) ? r : int'(da);
                r = r - sh_a;
                sh_b = (int'(db) > r) ? r : int'(db);
            end
        end
    end

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        if (armed && !done) begin
            n_tests++;
            if (gate !== exp_g) begin
                n_fail++;
                $display("FAIL %s cnt=%0d gate actual=%b expected=%b", cur_req, m_cnt, gate, exp_g);
            end
        end
    end

    task automatic check_eq(input string req, input logic [7:0] exp_v);
        n_tests++;
        if (gate !== exp_v) begin
            n_fail++;
            $display("FAIL %s directed actual=%b expected=%b", req, gate, exp_v);
        end
    endtask

    task automatic load(input int s, input int m, input int a, input int b, input int t);
        @(negedge clk);
        sec = 3'(s); mode = m[0]; da = CW'(a); db = CW'(b); st = CW'(t);
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic wait_last;
        @(negedge clk);
        while (m_cnt != P - 1) @(negedge clk);
    endtask

    task automatic periods(input int n);
        repeat (n * P) @(negedge clk);
    endtask

    initial begin
        // R1: reset holds all gates off
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check_eq("R1", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R3";
        periods(2);

        // R2: whole period of (1,-1) in sector 1 with no ST and no dwell
        cur_req = "R2";
        load(1, 0, 0, 0, 0);
        wait_last; @(negedge clk); @(negedge clk);
        check_eq("R2", 8'b1100_0011);
        periods(1);

        // R6: full-period shoot-through in basic mode
        cur_req = "R6";
        load(0, 0, 0, 0, P);
        wait_last; @(negedge clk); @(negedge clk);
        check_eq("R6", 8'hFF);
        periods(1);

        // R4 / R6: every sector, basic mode
        cur_req = "R4";
        for (int s = 0; s < 8; s++) begin
            load(s, 0, 5, 4, 6);
            periods(2);
        end

        // R5: odd shoot-through split
        cur_req = "R5";
        load(2, 0, 3, 7, 5);
        periods(2);
        load(5, 0, 1, 1, 1);
        periods(2);

        // R7: modified mode over all sectors
        cur_req = "R7";
        for (int s = 0; s < 8; s++) begin
            load(s, 1, 4, 6, 7);
            periods(2);
        end

        // R8: saturation
        cur_req = "R8";
        load(3, 0, 20, 20, 6);
        periods(2);
        load(6, 1, 9, 9, 30);
        periods(2);
        load(1, 1, 31, 5, 0);
        periods(2);

        // R10: zero-length slots
        cur_req = "R10";
        load(4, 1, 0, 8, 0);
        periods(2);
        load(7, 0, 0, 0, 2);
        periods(2);

        // R9: mid-period update, then a strobe on the wrap edge
        cur_req = "R9";
        load(2, 1, 6, 2, 4);
        periods(1);
        repeat (7) @(negedge clk);
        load(5, 0, 3, 3, 8);
        wait_last;
        sec = 3'd0; mode = 1'b1; da = CW'(2); db = CW'(9); st = CW'(3);
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        periods(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule